// File: doc/BRIEF.md
# Speech Frame Bitstream Packer and Unpacker

This block turns the quantized parameters of one 10 ms speech frame into a serial bitstream, and turns a received bitstream back into parameters. The frame holds two 5 ms sub-frames. On the transmit side a parallel word arrives through a valid/ready handshake together with a frame kind. The kind is a full speech frame, a short comfort-noise descriptor, or an empty slot. The packer inserts a protection bit computed over the upper part of the first pitch index. It then emits the frame one bit per clock and marks the first and last cycles of the frame.

The receive side takes a serial stream marked in the same way. It counts the bits between the start and end marks and decides the frame kind from that count. It slices the fields back out and reports, in a single cycle, whether the protection bit disagrees with the received pitch bits. The two sides are independent, so the transmit output can be looped straight into the receive input or driven from a line.

Back-pressure rules: the packer takes a word only on a cycle where both `in_valid` and `in_ready` are high. `in_ready` is low from the cycle after an accept until the cycle after the frame's last serial cycle. While it is low, the parallel inputs are not looked at. The serial output cannot be stalled. The receive side has no ready either: a decoded frame is shown for one cycle with `out_valid` and is not held.

Top module: `frame_bitpack`

## Requirements
- R1: After reset `in_ready` is 1 and `ser_valid`, `ser_sof`, `ser_eof`, `out_valid` and `parity_err` are 0.
- R2: A word is accepted only when `in_valid` and `in_ready` are both high, and `ser_sof` is high in the next cycle. `in_ready` stays low until the cycle after `ser_eof`. Input changes while `in_ready` is low have no effect on the frame being sent.
- R3: A speech frame (`in_type` = 1) is sent as 80 consecutive serial bits, each field MSB first, in this order: spectral field (18), pitch index 1 (8), protection bit (1), fixed code 1 (17), gain 1 (7), pitch delta 2 (5), fixed code 2 (17), gain 2 (7).
- R4: The protection bit is the XOR of pitch index 1 bits [7:2], so that those six bits plus the protection bit hold an even number of ones.
- R5: A descriptor frame (`in_type` = 2) is sent as the 15 bits of `in_sid`, MSB first.
- R6: An empty slot (`in_type` = 0 or 3) produces a single cycle with `ser_sof` = `ser_eof` = 1 and `ser_valid` = 0.
- R7: In a non-empty frame, `ser_valid` is high on every cycle from `ser_sof` to `ser_eof` inclusive. `ser_sof` marks the first bit and `ser_eof` marks the last bit, and `ser_valid` is low once the frame has ended.
- R8: One cycle after a cycle with `rx_eof` high, `out_valid` is high for one cycle. `out_type` is set by the count of valid bits since the last `rx_sof`: 80 gives 1 (speech), 15 gives 2 (descriptor), 0 gives 0 (empty), any other count gives 3 (malformed). The fields are decoded with the layout of R3/R5, and fields that do not belong to the decoded type read 0.
- R9: `parity_err` is high together with `out_valid` only for a speech frame whose received protection bit differs from the XOR of received pitch index 1 bits [7:2]. It is never high otherwise.
- R10: `rx_sof` discards any partially received bits, and counting restarts with the bit carried in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Parallel frame offered |
| in_ready | output | 1 | Packer can accept a frame |
| in_type | input | 2 | Frame kind: 1 speech, 2 descriptor, 0/3 empty |
| in_lsp | input | 18 | Spectral envelope field |
| in_p1 | input | 8 | Pitch index, sub-frame 1 |
| in_fc1 | input | 17 | Fixed codebook, sub-frame 1 |
| in_g1 | input | 7 | Gain code, sub-frame 1 |
| in_p2 | input | 5 | Differential pitch, sub-frame 2 |
| in_fc2 | input | 17 | Fixed codebook, sub-frame 2 |
| in_g2 | input | 7 | Gain code, sub-frame 2 |
| in_sid | input | 15 | Descriptor payload |
| ser_valid | output | 1 | Serial bit present |
| ser_bit | output | 1 | Serial data bit |
| ser_sof | output | 1 | First cycle of frame |
| ser_eof | output | 1 | Last cycle of frame |
| rx_valid | input | 1 | Received bit present |
| rx_bit | input | 1 | Received data bit |
| rx_sof | input | 1 | Received frame start |
| rx_eof | input | 1 | Received frame end |
| out_valid | output | 1 | Decoded frame strobe |
| out_type | output | 2 | Decoded kind: 0 empty, 1 speech, 2 descriptor, 3 malformed |
| out_lsp | output | 18 | Decoded spectral field |
| out_p1 | output | 8 | Decoded pitch index 1 |
| out_fc1 | output | 17 | Decoded fixed codebook 1 |
| out_g1 | output | 7 | Decoded gain 1 |
| out_p2 | output | 5 | Decoded pitch delta 2 |
| out_fc2 | output | 17 | Decoded fixed codebook 2 |
| out_g2 | output | 7 | Decoded gain 2 |
| out_sid | output | 15 | Decoded descriptor payload |
| parity_err | output | 1 | Protection-bit mismatch strobe |

## Verification
The packer always writes a correct protection bit, so a loopback can never reach the mismatch path. Malformed lengths and restarts in mid-frame cannot come from the packer either. To reach these cases the bench disconnects the loopback and drives the receive pins itself. It sends a speech frame with the protection bit inverted, a frame of 20 bits, and a partial frame that is cut off by a fresh start mark. Randomly chosen frames of every kind go through the loopback. During each of them the bench changes the parallel inputs while `in_ready` is low, which exercises the rule that inputs are ignored.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  parameter int LSP_W    = 18;
  parameter int P1_W     = 8;
  parameter int PAR_SPAN = 6;
  parameter int FC_W     = 17;
  parameter int GN_W     = 7;
  parameter int P2_W     = 5;
  parameter int SID_W    = 15;

  localparam int SPEECH_LEN = LSP_W + P1_W + 1 + 2 * FC_W + 2 * GN_W + P2_W;
  localparam int PAR_POS    = SPEECH_LEN - LSP_W - P1_W - 1;
  localparam int CNT_W      = $clog2(SPEECH_LEN + 2);

  typedef enum logic [1:0] {
    FT_NONE   = 2'd0,
    FT_SPEECH = 2'd1,
    FT_SID    = 2'd2,
    FT_BAD    = 2'd3
  } ftype_e;

  typedef struct packed {
    logic [LSP_W-1:0] lsp;
    logic [P1_W-1:0]  p1;
    logic [FC_W-1:0]  fc1;
    logic [GN_W-1:0]  g1;
    logic [P2_W-1:0]  p2;
    logic [FC_W-1:0]  fc2;
    logic [GN_W-1:0]  g2;
  } speech_t;

  function automatic logic pitch_parity(input logic [P1_W-1:0] p);
    return ^p[P1_W-1 -: PAR_SPAN];
  endfunction
endpackage

// File: rtl/fbp_packer.sv
module fbp_packer
  import fbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_type,
  input  speech_t          sp,
  input  logic [SID_W-1:0] sid,
  output logic             ser_valid,
  output logic             ser_bit,
  output logic             ser_sof,
  output logic             ser_eof
);
  logic                  busy, first;
  logic [SPEECH_LEN-1:0] sh;
  logic [CNT_W-1:0]      left;
  logic [SPEECH_LEN-1:0] load_vec;
  logic [CNT_W-1:0]      load_len;

  always_comb begin
    case (in_type)
      FT_SPEECH: begin
        load_vec = {sp.lsp, sp.p1, pitch_parity(sp.p1), sp.fc1, sp.g1,
                    sp.p2, sp.fc2, sp.g2};
        load_len = CNT_W'(SPEECH_LEN);
      end
      FT_SID: begin
        load_vec = {sid, {(SPEECH_LEN - SID_W){1'b0}}};
        load_len = CNT_W'(SID_W);
      end
      default: begin
        load_vec = '0;
        load_len = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      first <= 1'b0;
      sh    <= '0;
      left  <= '0;
    end else if (!busy) begin
      if (in_valid) begin
        busy  <= 1'b1;
        first <= 1'b1;
        sh    <= load_vec;
        left  <= load_len;
      end
    end else begin
      first <= 1'b0;
      if (left < CNT_W'(2)) begin
        busy <= 1'b0;
      end else begin
        left <= left - CNT_W'(1);
        sh   <= sh << 1;
      end
    end
  end

  assign in_ready  = !busy;
  assign ser_valid = busy && (left != '0);
  assign ser_bit   = ser_valid && sh[SPEECH_LEN-1];
  assign ser_sof   = busy && first;
  assign ser_eof   = busy && (left < CNT_W'(2));

  // R2
  accept_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> ser_sof);
  // R2
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> !in_ready);
  // R7
  eof_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_eof |=> !ser_valid);
  // R6
  empty_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_sof && !ser_valid |-> ser_eof);
endmodule

// File: rtl/fbp_unpacker.sv
module fbp_unpacker
  import fbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             out_valid,
  output logic [1:0]       out_type,
  output speech_t          sp_out,
  output logic [SID_W-1:0] sid_out,
  output logic             parity_err
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SPEECH_LEN + 1);

  logic [SPEECH_LEN-1:0] acc, acc_n;
  logic [CNT_W-1:0]      cnt, cnt_n;
  speech_t               rx_sp;
  ftype_e                kind;

  always_comb begin
    acc_n = acc;
    cnt_n = cnt;
    if (rx_sof) begin
      acc_n = '0;
      cnt_n = '0;
    end
    if (rx_valid) begin
      acc_n = {acc_n[SPEECH_LEN-2:0], rx_bit};
      if (cnt_n != SAT) cnt_n = cnt_n + CNT_W'(1);
    end
  end

  assign rx_sp = speech_t'({acc_n[SPEECH_LEN-1:PAR_POS+1], acc_n[PAR_POS-1:0]});

  always_comb begin
    if (cnt_n == CNT_W'(SPEECH_LEN))  kind = FT_SPEECH;
    else if (cnt_n == CNT_W'(SID_W))  kind = FT_SID;
    else if (cnt_n == '0)             kind = FT_NONE;
    else                              kind = FT_BAD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc        <= '0;
      cnt        <= '0;
      out_valid  <= 1'b0;
      out_type   <= FT_NONE;
      sp_out     <= '0;
      sid_out    <= '0;
      parity_err <= 1'b0;
    end else begin
      acc        <= acc_n;
      cnt        <= cnt_n;
      out_valid  <= rx_eof;
      parity_err <= 1'b0;
      if (rx_eof) begin
        out_type   <= kind;
        sp_out     <= (kind == FT_SPEECH) ? rx_sp : '0;
        sid_out    <= (kind == FT_SID) ? acc_n[SID_W-1:0] : '0;
        parity_err <= (kind == FT_SPEECH) &&
                      (pitch_parity(rx_sp.p1) != acc_n[PAR_POS]);
      end
    end
  end

  // R8
  eof_reports_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_eof |=> out_valid);
  // R9
  perr_speech_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> out_valid && out_type == FT_SPEECH);
endmodule

// File: rtl/frame_bitpack.sv
module frame_bitpack
  import fbp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [1:0]       in_type,
  input  logic [LSP_W-1:0] in_lsp,
  input  logic [P1_W-1:0]  in_p1,
  input  logic [FC_W-1:0]  in_fc1,
  input  logic [GN_W-1:0]  in_g1,
  input  logic [P2_W-1:0]  in_p2,
  input  logic [FC_W-1:0]  in_fc2,
  input  logic [GN_W-1:0]  in_g2,
  input  logic [SID_W-1:0] in_sid,
  output logic             ser_valid,
  output logic             ser_bit,
  output logic             ser_sof,
  output logic             ser_eof,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             out_valid,
  output logic [1:0]       out_type,
  output logic [LSP_W-1:0] out_lsp,
  output logic [P1_W-1:0]  out_p1,
  output logic [FC_W-1:0]  out_fc1,
  output logic [GN_W-1:0]  out_g1,
  output logic [P2_W-1:0]  out_p2,
  output logic [FC_W-1:0]  out_fc2,
  output logic [GN_W-1:0]  out_g2,
  output logic [SID_W-1:0] out_sid,
  output logic             parity_err
);
  speech_t tx_sp, rx_sp;

  assign tx_sp = '{lsp: in_lsp, p1: in_p1, fc1: in_fc1, g1: in_g1,
                   p2: in_p2, fc2: in_fc2, g2: in_g2};

  fbp_packer u_pack (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .sp(tx_sp), .sid(in_sid),
    .ser_valid(ser_valid), .ser_bit(ser_bit), .ser_sof(ser_sof), .ser_eof(ser_eof)
  );

  fbp_unpacker u_unpack (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_bit(rx_bit),
    .rx_sof(rx_sof), .rx_eof(rx_eof), .out_valid(out_valid), .out_type(out_type),
    .sp_out(rx_sp), .sid_out(out_sid), .parity_err(parity_err)
  );

  assign out_lsp = rx_sp.lsp;
  assign out_p1  = rx_sp.p1;
  assign out_fc1 = rx_sp.fc1;
  assign out_g1  = rx_sp.g1;
  assign out_p2  = rx_sp.p2;
  assign out_fc2 = rx_sp.fc2;
  assign out_g2  = rx_sp.g2;
endmodule

// File: tb/tb_frame_bitpack.sv
`timescale 1ns/1ps
module tb_frame_bitpack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic in_valid = 1'b0, in_ready;
  logic [1:0] in_type = '0;
  logic [17:0] in_lsp = '0; logic [7:0] in_p1 = '0; logic [16:0] in_fc1 = '0;
  logic [6:0] in_g1 = '0; logic [4:0] in_p2 = '0; logic [16:0] in_fc2 = '0;
  logic [6:0] in_g2 = '0; logic [14:0] in_sid = '0;
  logic ser_valid, ser_bit, ser_sof, ser_eof;
  logic rx_valid, rx_bit, rx_sof, rx_eof;
  logic use_loop = 1'b1;
  logic d_valid = 1'b0, d_bit = 1'b0, d_sof = 1'b0, d_eof = 1'b0;
  logic out_valid, parity_err;
  logic [1:0] out_type;
  logic [17:0] out_lsp; logic [7:0] out_p1; logic [16:0] out_fc1; logic [6:0] out_g1;
  logic [4:0] out_p2; logic [16:0] out_fc2; logic [6:0] out_g2; logic [14:0] out_sid;

  assign rx_valid = use_loop ? ser_valid : d_valid;
  assign rx_bit   = use_loop ? ser_bit   : d_bit;
  assign rx_sof   = use_loop ? ser_sof   : d_sof;
  assign rx_eof   = use_loop ? ser_eof   : d_eof;

  frame_bitpack dut (.*);

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [79:0] exp_speech(input logic [17:0] l, input logic [7:0] p1,
      input logic [16:0] f1, input logic [6:0] g1, input logic [4:0] p2,
      input logic [16:0] f2, input logic [6:0] g2, input bit flip);
    return {l, p1, (^p1[7:2]) ^ flip, f1, g1, p2, f2, g2};
  endfunction

  task automatic rand_fields();
    in_lsp = 18'($urandom); in_p1 = 8'($urandom); in_fc1 = 17'($urandom);
    in_g1 = 7'($urandom); in_p2 = 5'($urandom); in_fc2 = 17'($urandom);
    in_g2 = 7'($urandom); in_sid = 15'($urandom);
  endtask

  // Send one frame through the packer and loop it back into the unpacker.
  task automatic send_frame(input logic [1:0] t);
    logic [79:0] got, expv;
    logic [17:0] l; logic [7:0] a; logic [16:0] f1; logic [6:0] g1;
    logic [4:0] b; logic [16:0] f2; logic [6:0] g2; logic [14:0] s;
    int n, explen;
    logic [1:0] etype;
    bit sof_first;
    l = in_lsp; a = in_p1; f1 = in_fc1; g1 = in_g1; b = in_p2; f2 = in_fc2; g2 = in_g2; s = in_sid;
    explen = (t == 2'd1) ? 80 : (t == 2'd2) ? 15 : 0;
    etype  = (t == 2'd1) ? 2'd1 : (t == 2'd2) ? 2'd2 : 2'd0;
    expv   = (t == 2'd1) ? exp_speech(l, a, f1, g1, b, f2, g2, 1'b0) :
             (t == 2'd2) ? {65'b0, s} : 80'b0;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_type = t; in_valid = 1'b1;
    @(negedge clk);
    chk(ser_sof == 1'b1, "R2 sof after accept", 80'(ser_sof), 80'd1);
    chk(in_ready == 1'b0, "R2 ready low while busy", 80'(in_ready), 80'd0);
    sof_first = ser_sof;
    n = 0; got = '0;
    for (int k = 0; k < 100; k++) begin
      if (ser_valid) begin got = {got[78:0], ser_bit}; n++; end
      if (k > 0 && ser_sof) sof_first = 1'b0;
      if (explen > 0 && !ser_valid)
        chk(1'b0, "R7 valid gap inside frame", 80'(ser_valid), 80'd1);
      if (ser_eof) break;
      rand_fields();
      in_type = 2'($urandom);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(sof_first, "R7 single sof", 80'(sof_first), 80'd1);
    chk(n == explen, "R3/R5/R6 bit count", 80'(n), 80'(explen));
    if (t == 2'd1) chk(got == expv, "R3 R4 speech bit order", got, expv);
    else if (t == 2'd2) chk(got == expv, "R5 descriptor bits", got, expv);
    else chk(n == 0, "R6 empty slot", 80'(n), 80'd0);
    @(negedge clk);
    chk(ser_valid == 1'b0, "R7 valid low after eof", 80'(ser_valid), 80'd0);
    chk(in_ready == 1'b1, "R2 ready after eof", 80'(in_ready), 80'd1);
    chk(out_valid == 1'b1, "R8 out_valid", 80'(out_valid), 80'd1);
    chk(out_type == etype, "R8 out_type", 80'(out_type), 80'(etype));
    chk(parity_err == 1'b0, "R9 no parity error on loopback", 80'(parity_err), 80'd0);
    if (t == 2'd1)
      chk({out_lsp, out_p1, out_fc1, out_g1, out_p2, out_fc2, out_g2} == {l, a, f1, g1, b, f2, g2},
          "R8 speech fields", 80'({out_lsp, out_p1, out_fc1, out_g1, out_p2, out_fc2, out_g2}),
          80'({l, a, f1, g1, b, f2, g2}));
    if (t == 2'd2) chk(out_sid == s, "R8 descriptor field", 80'(out_sid), 80'(s));
  endtask

  // Drive the receive pins directly with len bits of v (right aligned).
  task automatic drive_rx(input logic [79:0] v, input int len, input bit with_eof);
    if (len == 0) begin
      @(negedge clk);
      d_sof = 1'b1; d_eof = with_eof; d_valid = 1'b0;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      d_sof = (i == 0); d_valid = 1'b1; d_bit = v[len-1-i];
      d_eof = with_eof && (i == len - 1);
    end
    @(negedge clk);
    d_sof = 1'b0; d_eof = 1'b0; d_valid = 1'b0; d_bit = 1'b0;
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [79:0] v;
    void'($urandom(32'd20241));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(in_ready == 1'b1, "R1 in_ready", 80'(in_ready), 80'd1);
    chk({ser_valid, ser_sof, ser_eof, out_valid, parity_err} == 5'b0, "R1 outputs idle",
        80'({ser_valid, ser_sof, ser_eof, out_valid, parity_err}), 80'd0);

    // Directed corner values
    in_lsp = '1; in_p1 = 8'hFC; in_fc1 = '1; in_g1 = '1; in_p2 = '1; in_fc2 = '1; in_g2 = '1;
    send_frame(2'd1);  // R4 six ones -> protection 0
    in_lsp = '0; in_p1 = 8'h07; in_fc1 = '0; in_g1 = '0; in_p2 = '0; in_fc2 = '0; in_g2 = '0;
    send_frame(2'd1);  // R4 one upper bit set -> protection 1
    in_sid = 15'h4001; send_frame(2'd2);
    send_frame(2'd0);
    send_frame(2'd3);  // R6 type 3 behaves as empty
    send_frame(2'd0);  // back-to-back empty slots

    // Random frames
    for (int i = 0; i < 60; i++) begin
      rand_fields();
      send_frame(2'($urandom));
    end

    // Direct receive-side cases
    use_loop = 1'b1;
    @(negedge clk);
    use_loop = 1'b0;
    rand_fields();
    v = exp_speech(in_lsp, in_p1, in_fc1, in_g1, in_p2, in_fc2, in_g2, 1'b1);
    drive_rx(v, 80, 1'b1);
    chk(out_valid && out_type == 2'd1, "R8 flipped frame type", 80'(out_type), 80'd1);
    chk(parity_err == 1'b1, "R9 parity error flagged", 80'(parity_err), 80'd1);
    chk(out_p1 == in_p1, "R9 pitch still decoded", 80'(out_p1), 80'(in_p1));
    @(negedge clk);
    chk(parity_err == 1'b0 && out_valid == 1'b0, "R9 one-cycle strobe",
        80'({out_valid, parity_err}), 80'd0);

    drive_rx(80'(20'hABCDE), 20, 1'b1);
    chk(out_valid && out_type == 2'd3, "R8 malformed length", 80'(out_type), 80'd3);
    chk(parity_err == 1'b0, "R9 no error on malformed", 80'(parity_err), 80'd0);

    drive_rx(80'h3FF, 10, 1'b0);
    drive_rx(80'(15'h2AB5), 15, 1'b1);
    chk(out_valid && out_type == 2'd2, "R10 restart gives descriptor", 80'(out_type), 80'd2);
    chk(out_sid == 15'h2AB5, "R10 descriptor payload", 80'(out_sid), 80'h2AB5);

    drive_rx(80'h0, 0, 1'b1);
    chk(out_valid && out_type == 2'd0, "R8 empty slot decode", 80'(out_type), 80'd0);
    chk(out_sid == 15'd0 && out_lsp == 18'd0, "R8 unused fields zero",
        80'({out_sid, out_lsp}), 80'd0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule